// File: doc/BRIEF.md
# LCD Frame-Buffer Fetch Address Generator

This block reads frame-buffer memory on behalf of an LCD controller and fills one input FIFO per fetch channel. In single-panel mode only channel 0 runs. In dual-panel mode channel 0 serves the upper half of the screen and channel 1 serves the lower half. Each channel has a base address and a current read pointer. The block works out where each channel must stop from the display geometry that software programs: pixels per line, lines per frame, pixel depth and panel mode. Software never gives a transfer length.

Memory is read in fixed bursts of four 32-bit words over a simple request/acknowledge handshake. Read data returns one word per cycle. A channel's region runs from its base address to a computed end address, and that span includes:
- a palette area, which only channel 0 has;
- a one-burst margin at the end, to cover overshoot;
- the encoded pixel data.

Lines are padded up to a whole number of 16 pixels. Every frame pulse does three things: it flushes both FIFOs, reloads the read pointers and latches a fresh copy of the configuration. Any words fetched past the end of the previous frame are therefore discarded.

Top module: `lcd_fb_dma`

## Requirements
- R1: After reset `bus_req` is 0, `fifo_avail` is 2'b00 and `cfg_err` is 0. No burst is requested before the first `frame_pulse`.
- R2: `cfg_bpp` encodes the pixel depth: 0 = 4 bpp, 1 = 8 bpp, 2 = 12 bpp, 3 = 16 bpp. Let P be the number of pixel bytes in a frame:
  - at 4 bpp, P = lines × ceil16(cols) / 2;
  - at 8 bpp, P = lines × ceil16(cols);
  - at 12 or 16 bpp, P = lines × cols × 2.

  Channel 0's region is palette + 16 + P bytes, where the palette is 512 bytes at 8 bpp and 32 bytes otherwise. Bursts are requested while the current pointer is below base + region size, so a frame takes ceil(size/16) bursts.
- R3: Every burst address is 16-byte aligned. A channel's bursts start at its base address and rise by 16 each time. `bus_req`, `bus_addr` and `bus_ch` hold steady until `bus_ack`.
- R4: `bus_ch` = 0 selects channel 0 and `bus_ch` = 1 selects channel 1. Channel 1 issues requests only in dual-panel mode (`cfg_dual` = 1). In dual-panel mode each channel gets P/2 pixel bytes, and channel 1's region has no palette: its size is 16 + P/2.
- R5: When both channels have work and FIFO room, consecutive bursts alternate between the channels.
- R6: A channel requests a burst only when its FIFO has at least 4 free words. With no reads from the FIFO, a channel of depth 8 stops after 2 bursts and resumes as it drains.
- R7: The cycle after `frame_pulse`, both FIFOs are empty. Words still returning from a burst issued before the pulse are discarded. The first burst of the new frame reads the channel's base address.
- R8: If a base address in use has any of bits [3:0] set, `cfg_err` is 1 for that frame and no burst is requested. Channel 1's base is checked only in dual-panel mode.
- R9: The configuration inputs take effect only at a `frame_pulse`. Changes made mid-frame do not alter the current frame's fetch.
- R10: Each channel FIFO delivers returned words in address order. The head word appears on `fifoN_data` while `fifo_avail[N]` is 1, and `fifo_pop[N]` removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_pulse | input | 1 | Frame start: latch configuration, reload pointers, flush FIFOs |
| cfg_dual | input | 1 | 1 = dual-panel (two channels) |
| cfg_bpp | input | 2 | Pixel depth code (0:4, 1:8, 2:12, 3:16 bpp) |
| cfg_cols | input | COL_W | Pixels per line |
| cfg_lines | input | LINE_W | Lines per frame (per whole screen) |
| cfg_base0 | input | AW | Channel 0 base byte address |
| cfg_base1 | input | AW | Channel 1 base byte address |
| cfg_err | output | 1 | Misaligned base in the latched configuration |
| bus_req | output | 1 | Burst read request |
| bus_addr | output | AW | Burst start byte address |
| bus_ch | output | 1 | Channel owning the requested burst |
| bus_ack | input | 1 | Request accepted |
| bus_rvalid | input | 1 | Read data word valid |
| bus_rdata | input | DW | Read data word |
| fifo_pop | input | 2 | Remove head word of channel N FIFO |
| fifo_avail | output | 2 | Channel N FIFO holds data |
| fifo0_data | output | DW | Channel 0 FIFO head word |
| fifo1_data | output | DW | Channel 1 FIFO head word |

## Verification
The hardest case to reach is a frame pulse that lands while a burst is still in flight. For R7 to hold, the returning words must vanish and the pointer must restart cleanly. To get there, the stimulus starts a long 8 bpp frame with a consumer that drains at full rate, which keeps bursts back to back. It then issues a second pulse mid-stream. The bench accepts either zero or one stale acknowledged burst. It then requires that the remaining bursts start at the base address and that the popped words form an unbroken sequence from the base. FIFO back-pressure is the other condition that is hard to reach. It is produced by starting a frame with the consumer switched off.

// File: rtl/lcd_fb_dma_pkg.sv
package lcd_fb_dma_pkg;

    typedef enum logic [1:0] {
        BPP_4  = 2'd0,
        BPP_8  = 2'd1,
        BPP_12 = 2'd2,
        BPP_16 = 2'd3
    } bpp_e;

    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_REQ  = 2'd1,
        BUS_DATA = 2'd2
    } bus_st_e;

    localparam int unsigned BURST_WORDS = 4;
    localparam int unsigned PAL_SMALL_B = 32;
    localparam int unsigned PAL_LARGE_B = 512;
    localparam int unsigned LINE_QUANT  = 16;

endpackage

// File: rtl/lcd_fb_span.sv
// End-address calculator for one fetch channel, driven from latched geometry.
module lcd_fb_span
    import lcd_fb_dma_pkg::*;
#(
    parameter int AW      = 32,
    parameter int COL_W   = 11,
    parameter int LINE_W  = 10,
    parameter bit HAS_PAL = 1'b1,
    parameter int OVER_B  = 16
) (
    input  bpp_e              bpp,
    input  logic [COL_W-1:0]  cols,
    input  logic [LINE_W-1:0] lines,
    input  logic              dual,
    input  logic [AW-1:0]     base,
    output logic [AW-1:0]     end_addr
);
    localparam int LB_W = COL_W + 2;
    localparam int PX_W = LB_W + LINE_W;
    localparam logic [LB_W-1:0] QMASK = LB_W'(LINE_QUANT - 1);

    logic [LB_W-1:0] padded;
    logic [LB_W-1:0] line_b;
    logic [PX_W-1:0] pix;
    logic [PX_W-1:0] share;
    logic [AW-1:0]   pal;

    always_comb begin
        // pad each line up to a whole multiple of 16 pixels
        padded = (LB_W'(cols) + QMASK) & ~QMASK;
        unique case (bpp)
            BPP_4:   line_b = padded >> 1;
            BPP_8:   line_b = padded;
            default: line_b = LB_W'(cols) << 1;
        endcase
        pix   = PX_W'(line_b) * PX_W'(lines);
        share = dual ? (pix >> 1) : pix;
        if (!HAS_PAL)
            pal = '0;
        else if (bpp == BPP_8)
            pal = AW'(PAL_LARGE_B);
        else
            pal = AW'(PAL_SMALL_B);
        end_addr = base + pal + AW'(OVER_B) + AW'(share);
    end
endmodule

// File: rtl/lcd_fb_fifo.sv
// Show-ahead word FIFO with synchronous flush; flush wins over push and pop.
module lcd_fb_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [DW-1:0]    wdata,
    input  logic             pop,
    output logic [DW-1:0]    rdata,
    output logic             avail,
    output logic [CNT_W-1:0] fill
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fst_t;

    fst_t          f_d, f_q;
    logic [DW-1:0] mem [DEPTH];
    logic          wr_en, rd_en;

    always_comb begin
        f_d   = f_q;
        wr_en = push && (f_q.cnt != FULL);
        rd_en = pop && (f_q.cnt != '0);
        if (wr_en) f_d.wr = f_q.wr + 1'b1;
        if (rd_en) f_d.rd = f_q.rd + 1'b1;
        if (wr_en && !rd_en)
            f_d.cnt = f_q.cnt + 1'b1;
        else if (!wr_en && rd_en)
            f_d.cnt = f_q.cnt - 1'b1;
        if (flush) f_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en && !flush) mem[f_q.wr] <= wdata;
    end

    assign rdata = mem[f_q.rd];
    assign avail = (f_q.cnt != '0);
    assign fill  = f_q.cnt;
endmodule

// File: rtl/lcd_fb_dma.sv
// Two-channel frame-buffer fetcher: end-address derivation, burst arbitration,
// frame-synchronous flush.
module lcd_fb_dma
    import lcd_fb_dma_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int COL_W      = 11,
    parameter int LINE_W     = 10,
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_pulse,
    input  logic              cfg_dual,
    input  logic [1:0]        cfg_bpp,
    input  logic [COL_W-1:0]  cfg_cols,
    input  logic [LINE_W-1:0] cfg_lines,
    input  logic [AW-1:0]     cfg_base0,
    input  logic [AW-1:0]     cfg_base1,
    output logic              cfg_err,
    output logic              bus_req,
    output logic [AW-1:0]     bus_addr,
    output logic              bus_ch,
    input  logic              bus_ack,
    input  logic              bus_rvalid,
    input  logic [DW-1:0]     bus_rdata,
    input  logic [1:0]        fifo_pop,
    output logic [1:0]        fifo_avail,
    output logic [DW-1:0]     fifo0_data,
    output logic [DW-1:0]     fifo1_data
);
    localparam int BURST_B = BURST_WORDS * DW / 8;
    localparam int BEAT_W  = $clog2(BURST_WORDS);
    localparam int CNT_W   = $clog2(FIFO_DEPTH + 1);
    localparam int ALIGN_W = $clog2(BURST_B);
    localparam logic [CNT_W-1:0]  ROOM_MAX  = CNT_W'(FIFO_DEPTH - BURST_WORDS);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_WORDS - 1);

    typedef struct packed {
        logic                   active;
        logic                   err;
        logic                   dual;
        logic                   prio;
        logic                   drop;
        logic                   ch;
        bpp_e                   bpp;
        logic [COL_W-1:0]       cols;
        logic [LINE_W-1:0]      lines;
        logic [1:0][AW-1:0]     base;
        logic [1:0][AW-1:0]     cur;
        bus_st_e                st;
        logic [BEAT_W-1:0]      beat;
        logic [AW-1:0]          addr;
    } st_t;

    st_t                   s_d, s_q;
    logic [1:0][AW-1:0]    end_addr;
    logic [1:0][CNT_W-1:0] fill;
    logic [1:0][DW-1:0]    rd_data;
    logic [1:0]            push;
    logic [1:0]            elig;
    logic                  pick;
    logic                  misalign;
    logic                  shadow_dual;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_ch
            lcd_fb_span #(
                .AW      (AW),
                .COL_W   (COL_W),
                .LINE_W  (LINE_W),
                .HAS_PAL (g == 0),
                .OVER_B  (BURST_B)
            ) u_span (
                .bpp      (s_q.bpp),
                .cols     (s_q.cols),
                .lines    (s_q.lines),
                .dual     (s_q.dual),
                .base     (s_q.base[g]),
                .end_addr (end_addr[g])
            );

            lcd_fb_fifo #(
                .DW    (DW),
                .DEPTH (FIFO_DEPTH)
            ) u_fifo (
                .clk   (clk),
                .rst_n (rst_n),
                .flush (frame_pulse),
                .push  (push[g]),
                .wdata (bus_rdata),
                .pop   (fifo_pop[g]),
                .rdata (rd_data[g]),
                .avail (fifo_avail[g]),
                .fill  (fill[g])
            );
        end
    endgenerate

    assign misalign = (|cfg_base0[ALIGN_W-1:0]) |
                      (cfg_dual & (|cfg_base1[ALIGN_W-1:0]));

    always_comb begin
        s_d  = s_q;
        push = 2'b00;

        for (int i = 0; i < 2; i++) begin
            elig[i] = s_q.active && !s_q.err && ((i == 0) || s_q.dual) &&
                      (s_q.cur[i] < end_addr[i]) && (fill[i] <= ROOM_MAX);
        end
        pick = (elig[0] && elig[1]) ? s_q.prio : elig[1];

        unique case (s_q.st)
            BUS_IDLE: begin
                if ((|elig) && !frame_pulse) begin
                    s_d.st   = BUS_REQ;
                    s_d.ch   = pick;
                    s_d.addr = s_q.cur[pick];
                end
            end
            BUS_REQ: begin
                if (bus_ack) begin
                    s_d.st   = BUS_DATA;
                    s_d.beat = '0;
                end
            end
            BUS_DATA: begin
                if (bus_rvalid) begin
                    push[s_q.ch] = !s_q.drop;
                    s_d.beat     = s_q.beat + 1'b1;
                    if (s_q.beat == LAST_BEAT) begin
                        s_d.st   = BUS_IDLE;
                        s_d.drop = 1'b0;
                        s_d.prio = ~s_q.ch;
                        if (!s_q.drop)
                            s_d.cur[s_q.ch] = s_q.cur[s_q.ch] + AW'(BURST_B);
                    end
                end
            end
            default: s_d.st = BUS_IDLE;
        endcase

        // frame start: latch configuration and restart both channels
        if (frame_pulse) begin
            s_d.active  = 1'b1;
            s_d.err     = misalign;
            s_d.dual    = cfg_dual;
            s_d.bpp     = bpp_e'(cfg_bpp);
            s_d.cols    = cfg_cols;
            s_d.lines   = cfg_lines;
            s_d.base[0] = cfg_base0;
            s_d.base[1] = cfg_base1;
            s_d.cur[0]  = cfg_base0;
            s_d.cur[1]  = cfg_base1;
            s_d.drop    = (s_d.st != BUS_IDLE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cfg_err     = s_q.err;
    assign bus_req     = (s_q.st == BUS_REQ);
    assign bus_addr    = s_q.addr;
    assign bus_ch      = s_q.ch;
    assign fifo0_data  = rd_data[0];
    assign fifo1_data  = rd_data[1];
    assign shadow_dual = s_q.dual;
endmodule

// File: rtl/lcd_fb_dma_chk.sv
module lcd_fb_dma_chk #(
    parameter int AW            = 32,
    parameter int CNT_W         = 4,
    parameter int FIFO_DEPTH    = 8,
    parameter int BURST_WORDS_P = 4,
    parameter int ALIGN_W       = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  frame_pulse,
    input logic                  bus_req,
    input logic                  bus_ack,
    input logic [AW-1:0]         bus_addr,
    input logic                  bus_ch,
    input logic                  cfg_err,
    input logic                  shadow_dual,
    input logic [1:0]            fifo_avail,
    input logic [1:0][CNT_W-1:0] fill
);
    localparam logic [CNT_W-1:0] ROOM = CNT_W'(FIFO_DEPTH - BURST_WORDS_P);

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_ch));

    assert_addr_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_addr[ALIGN_W-1:0] == '0));

    assert_single_ch0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) && !shadow_dual |-> !bus_ch);

    assert_room_ch0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) && !bus_ch |-> fill[0] <= ROOM);

    assert_room_ch1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) && bus_ch |-> fill[1] <= ROOM);

    assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> fifo_avail == 2'b00);

    assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err && !bus_req |=> !bus_req);
endmodule

bind lcd_fb_dma lcd_fb_dma_chk #(
    .AW            (AW),
    .CNT_W         (CNT_W),
    .FIFO_DEPTH    (FIFO_DEPTH),
    .BURST_WORDS_P (BURST_WORDS),
    .ALIGN_W       (ALIGN_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_pulse (frame_pulse),
    .bus_req     (bus_req),
    .bus_ack     (bus_ack),
    .bus_addr    (bus_addr),
    .bus_ch      (bus_ch),
    .cfg_err     (cfg_err),
    .shadow_dual (shadow_dual),
    .fifo_avail  (fifo_avail),
    .fill        (fill)
);

// File: tb/lcd_fb_dma_bench.sv
`timescale 1ns/1ps
module lcd_fb_dma_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_pulse;
    logic        cfg_dual;
    logic [1:0]  cfg_bpp;
    logic [10:0] cfg_cols;
    logic [9:0]  cfg_lines;
    logic [31:0] cfg_base0, cfg_base1;
    logic        cfg_err;
    logic        bus_req;
    logic [31:0] bus_addr;
    logic        bus_ch;
    logic        bus_ack;
    logic        bus_rvalid;
    logic [31:0] bus_rdata;
    logic [1:0]  fifo_pop;
    logic [1:0]  fifo_avail;
    logic [31:0] fifo0_data, fifo1_data;

    int          checks = 0;
    int          fails  = 0;
    logic        cons_en = 1'b0;
    int          pop_cnt [2];
    logic [31:0] exp_base [2];
    logic [31:0] log_addr [256];
    logic        log_ch   [256];
    int          log_n = 0;
    int          frame_mark = 0;
    logic [1:0]  avail_after;

    always #2 clk = ~clk;

    lcd_fb_dma u_lcd_fb_dma (
        .clk, .rst_n, .frame_pulse, .cfg_dual, .cfg_bpp, .cfg_cols, .cfg_lines,
        .cfg_base0, .cfg_base1, .cfg_err, .bus_req, .bus_addr, .bus_ch,
        .bus_ack, .bus_rvalid, .bus_rdata, .fifo_pop, .fifo_avail,
        .fifo0_data, .fifo1_data
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return a ^ 32'hC3C3_0000;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory responder: ack one cycle, then four data beats
    initial begin
        bus_ack = 1'b0; bus_rvalid = 1'b0; bus_rdata = '0;
        forever begin
            @(negedge clk);
            if (bus_req) begin
                logic [31:0] a;
                a = bus_addr;
                if (log_n < 256) begin
                    log_addr[log_n] = a;
                    log_ch[log_n]   = bus_ch;
                    log_n++;
                end
                bus_ack = 1'b1;
                @(negedge clk);
                bus_ack = 1'b0;
                for (int k = 0; k < 4; k++) begin
                    bus_rvalid = 1'b1;
                    bus_rdata  = pat(a + 32'(k * 4));
                    @(negedge clk);
                end
                bus_rvalid = 1'b0;
            end
        end
    end

    // consumer: pops any available word and checks its value (R10)
    initial begin
        fifo_pop = 2'b00;
        forever begin
            @(negedge clk);
            fifo_pop = 2'b00;
            if (cons_en) begin
                for (int c = 0; c < 2; c++) begin
                    if (fifo_avail[c]) begin
                        logic [31:0] got, exp;
                        got = (c == 0) ? fifo0_data : fifo1_data;
                        exp = pat(exp_base[c] + 32'(pop_cnt[c] * 4));
                        chk(got == exp, "R10", "fifo word order", got, exp);
                        pop_cnt[c]++;
                        fifo_pop[c] = 1'b1;
                    end
                end
            end
        end
    end

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_frame(input logic [31:0] b0, input logic [31:0] b1,
                               input logic d, input logic [1:0] bpp,
                               input int cols, input int lines, input logic en);
        @(posedge clk);
        cons_en    = 1'b0;
        frame_mark = log_n;
        @(negedge clk);
        cfg_base0 = b0; cfg_base1 = b1; cfg_dual = d; cfg_bpp = bpp;
        cfg_cols  = 11'(cols); cfg_lines = 10'(lines);
        frame_pulse = 1'b1;
        pop_cnt[0] = 0; pop_cnt[1] = 0;
        exp_base[0] = b0; exp_base[1] = b1;
        @(negedge clk);
        frame_pulse = 1'b0;
        avail_after = fifo_avail;
        @(posedge clk);
        cons_en = en;
    endtask

    function automatic int bursts_of(input logic c);
        int n = 0;
        for (int i = frame_mark; i < log_n; i++) if (log_ch[i] == c) n++;
        return n;
    endfunction

    function automatic bit seq_ok(input logic c, input logic [31:0] base);
        int k = 0;
        for (int i = frame_mark; i < log_n; i++) begin
            if (log_ch[i] == c) begin
                if (log_addr[i] != base + 32'(k * 16)) return 1'b0;
                k++;
            end
        end
        return 1'b1;
    endfunction

    task automatic test_reset();
        chk(bus_req == 1'b0, "R1", "bus_req after reset", 32'(bus_req), 0);
        chk(fifo_avail == 2'b00, "R1", "fifo_avail after reset", 32'(fifo_avail), 0);
        chk(cfg_err == 1'b0, "R1", "cfg_err after reset", 32'(cfg_err), 0);
        run(20);
        chk(log_n == 0, "R1", "no burst before frame", 32'(log_n), 0);
    endtask

    task automatic test_single_8bpp();
        start_frame(32'h1000, 32'h0, 1'b0, 2'd1, 16, 2, 1'b1);
        run(400);
        chk(bursts_of(1'b0) == 35, "R2", "8bpp bursts (512 palette)", 32'(bursts_of(1'b0)), 35);
        chk(bursts_of(1'b1) == 0, "R4", "channel 1 idle in single mode", 32'(bursts_of(1'b1)), 0);
        chk(seq_ok(1'b0, 32'h1000), "R3", "address sequence ch0", 0, 1);
        chk(pop_cnt[0] == 140, "R10", "words delivered", 32'(pop_cnt[0]), 140);
    endtask

    task automatic test_4bpp_pad();
        start_frame(32'h2000, 32'h0, 1'b0, 2'd0, 107, 3, 1'b1);
        run(200);
        chk(bursts_of(1'b0) == 14, "R2", "4bpp padded bursts", 32'(bursts_of(1'b0)), 14);
        chk(seq_ok(1'b0, 32'h2000), "R3", "address sequence 4bpp", 0, 1);
        chk(pop_cnt[0] == 56, "R10", "4bpp words", 32'(pop_cnt[0]), 56);
    endtask

    task automatic test_16bpp();
        start_frame(32'h2400, 32'h0, 1'b0, 2'd3, 20, 3, 1'b1);
        run(200);
        chk(bursts_of(1'b0) == 11, "R2", "16bpp bursts", 32'(bursts_of(1'b0)), 11);
        chk(pop_cnt[0] == 44, "R10", "16bpp words", 32'(pop_cnt[0]), 44);
    endtask

    task automatic test_dual();
        bit alt = 1'b1;
        start_frame(32'h4000, 32'h8000, 1'b1, 2'd1, 32, 4, 1'b1);
        run(600);
        chk(bursts_of(1'b0) == 37, "R4", "dual ch0 bursts", 32'(bursts_of(1'b0)), 37);
        chk(bursts_of(1'b1) == 5, "R4", "dual ch1 bursts (no palette)", 32'(bursts_of(1'b1)), 5);
        chk(seq_ok(1'b0, 32'h4000), "R3", "dual ch0 sequence", 0, 1);
        chk(seq_ok(1'b1, 32'h8000), "R3", "dual ch1 sequence", 0, 1);
        for (int i = 0; i < 9; i++)
            if (log_ch[frame_mark + i] == log_ch[frame_mark + i + 1]) alt = 1'b0;
        chk(alt, "R5", "alternating grants", 32'(alt), 1);
        chk(pop_cnt[1] == 20, "R10", "dual ch1 words", 32'(pop_cnt[1]), 20);
    endtask

    task automatic test_backpressure();
        start_frame(32'h1000, 32'h0, 1'b0, 2'd1, 16, 2, 1'b0);
        run(100);
        chk(log_n - frame_mark == 2, "R6", "bursts with full fifo", 32'(log_n - frame_mark), 2);
        chk(bus_req == 1'b0, "R6", "no request while full", 32'(bus_req), 0);
        @(posedge clk);
        cons_en = 1'b1;
        run(400);
        chk(bursts_of(1'b0) == 35, "R6", "resume after drain", 32'(bursts_of(1'b0)), 35);
        chk(pop_cnt[0] == 140, "R6", "all words after drain", 32'(pop_cnt[0]), 140);
    endtask

    task automatic test_cfg_latch();
        start_frame(32'h3000, 32'h0, 1'b0, 2'd2, 20, 3, 1'b1);
        run(10);
        cfg_cols = 11'd200; cfg_lines = 10'd50; cfg_bpp = 2'd1; cfg_dual = 1'b1;
        run(300);
        chk(bursts_of(1'b0) == 11, "R9", "mid-frame change ignored", 32'(bursts_of(1'b0)), 11);
        chk(bursts_of(1'b1) == 0, "R9", "dual change ignored", 32'(bursts_of(1'b1)), 0);
    endtask

    task automatic test_restart();
        int n;
        int first;
        start_frame(32'h1000, 32'h0, 1'b0, 2'd1, 16, 2, 1'b1);
        run(60);
        start_frame(32'h1000, 32'h0, 1'b0, 2'd1, 16, 2, 1'b1);
        chk(avail_after == 2'b00, "R7", "fifos flushed", 32'(avail_after), 0);
        run(400);
        n = log_n - frame_mark;
        chk(n == 35 || n == 36, "R7", "bursts after restart", 32'(n), 35);
        first = frame_mark + ((n == 36) ? 1 : 0);
        chk(log_addr[first] == 32'h1000, "R7", "restart at base", log_addr[first], 32'h1000);
        chk(pop_cnt[0] == 140, "R7", "no stale words", 32'(pop_cnt[0]), 140);
    endtask

    task automatic test_err();
        start_frame(32'h1008, 32'h0, 1'b0, 2'd1, 16, 2, 1'b1);
        run(50);
        chk(cfg_err == 1'b1, "R8", "misaligned base flagged", 32'(cfg_err), 1);
        chk(log_n - frame_mark == 0, "R8", "no fetch on error", 32'(log_n - frame_mark), 0);
        start_frame(32'h1000, 32'h0, 1'b0, 2'd1, 16, 2, 1'b1);
        run(5);
        chk(cfg_err == 1'b0, "R8", "error cleared by good frame", 32'(cfg_err), 0);
        run(400);
        chk(bursts_of(1'b0) == 35, "R8", "fetch after recovery", 32'(bursts_of(1'b0)), 35);
    endtask

    initial begin
        rst_n = 1'b0; frame_pulse = 1'b0; cfg_dual = 1'b0; cfg_bpp = 2'd0;
        cfg_cols = '0; cfg_lines = '0; cfg_base0 = '0; cfg_base1 = '0;
        pop_cnt[0] = 0; pop_cnt[1] = 0; exp_base[0] = '0; exp_base[1] = '0;
        avail_after = 2'b00;
        run(5);
        rst_n = 1'b1;
        run(1);
        test_reset();
        test_single_8bpp();
        test_4bpp_pad();
        test_16bpp();
        test_dual();
        test_backpressure();
        test_cfg_latch();
        test_restart();
        test_err();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule